// File: doc/BRIEF.md
# Sprite Attribute Page Copy Engine

This block moves one 256-byte page of main memory into the 256-byte sprite attribute RAM. The processor is held stalled for the whole copy. A single-cycle start strobe carries the source page number. With it come the sprite RAM offset at which writing begins and a flag that says whether the strobe cycle is odd. The engine then reads the page byte by byte in ascending order. Each byte goes to sprite RAM at the offset plus the byte index, and the destination wraps past the top of the 256-byte RAM back to zero.

Every transfer begins with one dead cycle. If the strobe came on an odd cycle, one more alignment cycle follows it. After that the engine alternates a read cycle and a write cycle for each byte. The stall output therefore lasts 513 cycles when the strobe is even and 514 when it is odd. A one-cycle done pulse follows the last write. Main memory is expected to return read data in the cycle after a read request, and that data is passed straight into the following write.

Top module: `sprite_copy_dma`

## Requirements
- R1: After reset, stall_o, done_o, rd_en_o and wr_en_o are all low.
- R2: Reads cover addresses page*256 + i for i = 0 up to 255, in ascending order, with exactly one read per byte.
- R3: Byte i is written to sprite RAM address (offset + i) mod 256, so a copy that starts at a non-zero offset wraps to address 0.
- R4: Each read cycle is followed directly by a write cycle. The write data is the value main memory returned for that read, which is valid in the cycle after the read request.
- R5: When the parity flag is 0 at the strobe, the first read comes in the second stalled cycle and stall lasts 513 cycles.
- R6: When the parity flag is 1 at the strobe, an alignment cycle is added, the first read comes in the third stalled cycle and stall lasts 514 cycles.
- R7: stall_o rises in the cycle after an accepted strobe and stays high without a gap through the cycle of the last write.
- R8: done_o is high for exactly one cycle, the cycle right after the last write, and stall_o is low in that cycle.
- R9: A strobe that arrives while a copy is running has no effect. The copy finishes with its original page, offset and length.
- R10: rd_en_o and wr_en_o are never high together, and both are low whenever stall_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle copy request |
| page_i | input | 8 | Source page number, sampled with start_i |
| base_i | input | 8 | Sprite RAM offset for the first byte, sampled with start_i |
| odd_i | input | 1 | High when the strobe cycle is odd, sampled with start_i |
| rd_data_i | input | 8 | Main memory read data, valid the cycle after rd_en_o |
| rd_addr_o | output | 16 | Main memory read address |
| rd_en_o | output | 1 | Main memory read request |
| wr_addr_o | output | 8 | Sprite RAM write address |
| wr_data_o | output | 8 | Sprite RAM write data |
| wr_en_o | output | 1 | Sprite RAM write enable |
| stall_o | output | 1 | Holds the processor while the copy runs |
| done_o | output | 1 | One-cycle pulse after the last write |

## Verification
A wrong byte index shows up in the very first read cycle that carries it, as a wrong low byte on rd_addr_o, and in the write that follows as a wrong wr_addr_o. A parity flag or phase state held with the wrong value shows up within the first two or three stalled cycles, because the first read lands in the wrong place. The full stall length then comes out wrong by one or more cycles. A stale page or offset register, for example one reloaded by a strobe that should have been ignored, shows up only in the addresses issued after that strobe. For this reason every address and every one of the 256 destination bytes is compared on each run.

// File: rtl/sprite_dma_pkg.sv
package sprite_dma_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_LEAD  = 3'd1,
        PH_ALIGN = 3'd2,
        PH_READ  = 3'd3,
        PH_WRITE = 3'd4
    } dma_phase_e;

    typedef struct packed {
        logic [7:0] page;
        logic [7:0] base;
    } copy_job_t;

    function automatic logic phase_is_busy(dma_phase_e ph);
        return ph != PH_IDLE;
    endfunction

endpackage

// File: rtl/sdma_sequencer.sv
module sdma_sequencer
    import sprite_dma_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             odd_i,
    output dma_phase_e       phase_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             accept_o,
    output logic             done_o
);
    localparam logic [IDX_W-1:0] IDX_LAST = {IDX_W{1'b1}};
    localparam logic [IDX_W-1:0] IDX_ONE  = {{(IDX_W-1){1'b0}}, 1'b1};

    dma_phase_e       phase_q, phase_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic             odd_q;
    logic             done_q;

    assign accept_o = (phase_q == PH_IDLE) && start_i;

    always_comb begin
        phase_d = phase_q;
        idx_d   = idx_q;
        unique case (phase_q)
            PH_IDLE:  if (start_i) begin
                          phase_d = PH_LEAD;
                          idx_d   = '0;
                      end
            PH_LEAD:  phase_d = odd_q ? PH_ALIGN : PH_READ;
            PH_ALIGN: phase_d = PH_READ;
            PH_READ:  phase_d = PH_WRITE;
            PH_WRITE: begin
                          idx_d   = idx_q + IDX_ONE;
                          phase_d = (idx_q == IDX_LAST) ? PH_IDLE : PH_READ;
                      end
            default:  phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            idx_q   <= '0;
            odd_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            phase_q <= phase_d;
            idx_q   <= idx_d;
            if (accept_o) odd_q <= odd_i;
            done_q  <= (phase_q == PH_WRITE) && (idx_q == IDX_LAST);
        end
    end

    assign phase_o = phase_q;
    assign idx_o   = idx_q;
    assign done_o  = done_q;

endmodule

// File: rtl/sdma_addr_gen.sv
module sdma_addr_gen #(
    parameter int PAGE_W = 8,
    parameter int IDX_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    load_i,
    input  logic [PAGE_W-1:0]       page_i,
    input  logic [IDX_W-1:0]        base_i,
    input  logic [IDX_W-1:0]        idx_i,
    output logic [PAGE_W+IDX_W-1:0] src_addr_o,
    output logic [IDX_W-1:0]        dst_addr_o
);
    logic [PAGE_W-1:0] page_q;
    logic [IDX_W-1:0]  base_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            page_q <= '0;
            base_q <= '0;
        end else if (load_i) begin
            page_q <= page_i;
            base_q <= base_i;
        end
    end

    // Source is the page concatenated with the index; destination wraps
    // naturally because the sum is truncated to IDX_W bits.
    assign src_addr_o = {page_q, idx_i};
    assign dst_addr_o = base_q + idx_i;

endmodule

// File: rtl/sprite_copy_dma.sv
module sprite_copy_dma
    import sprite_dma_pkg::*;
#(
    parameter int PAGE_W = 8,
    parameter int IDX_W  = 8,
    parameter int DATA_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start_i,
    input  logic [PAGE_W-1:0]       page_i,
    input  logic [IDX_W-1:0]        base_i,
    input  logic                    odd_i,
    input  logic [DATA_W-1:0]       rd_data_i,
    output logic [PAGE_W+IDX_W-1:0] rd_addr_o,
    output logic                    rd_en_o,
    output logic [IDX_W-1:0]        wr_addr_o,
    output logic [DATA_W-1:0]       wr_data_o,
    output logic                    wr_en_o,
    output logic                    stall_o,
    output logic                    done_o
);
    localparam int RD_W = PAGE_W + IDX_W;

    dma_phase_e       phase;
    logic [IDX_W-1:0] idx;
    logic             accept;
    logic [RD_W-1:0]  src_addr;
    logic [IDX_W-1:0] dst_addr;

    sdma_sequencer #(.IDX_W(IDX_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .odd_i    (odd_i),
        .phase_o  (phase),
        .idx_o    (idx),
        .accept_o (accept),
        .done_o   (done_o)
    );

    sdma_addr_gen #(.PAGE_W(PAGE_W), .IDX_W(IDX_W)) u_addr (
        .clk        (clk),
        .rst        (rst),
        .load_i     (accept),
        .page_i     (page_i),
        .base_i     (base_i),
        .idx_i      (idx),
        .src_addr_o (src_addr),
        .dst_addr_o (dst_addr)
    );

    assign rd_en_o   = (phase == PH_READ);
    assign wr_en_o   = (phase == PH_WRITE);
    assign rd_addr_o = src_addr;
    assign wr_addr_o = dst_addr;
    assign wr_data_o = rd_data_i;
    assign stall_o   = phase_is_busy(phase);

endmodule

// File: rtl/sprite_copy_dma_chk.sv
module sprite_copy_dma_chk (
    input logic clk,
    input logic rst,
    input logic start_i,
    input logic rd_en_o,
    input logic wr_en_o,
    input logic stall_o,
    input logic done_o
);
    // R10
    rw_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(rd_en_o && wr_en_o));

    // R10
    quiet_when_free_chk: assert property (@(posedge clk) disable iff (rst)
        !stall_o |-> (!rd_en_o && !wr_en_o));

    // R4
    read_then_write_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en_o |=> wr_en_o);

    // R7
    stall_follows_start_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && !stall_o) |=> stall_o);

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R8
    done_after_write_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!stall_o && $past(wr_en_o)));

    // R8
    stall_end_done_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(stall_o) |-> done_o);

endmodule

bind sprite_copy_dma sprite_copy_dma_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .rd_en_o (rd_en_o),
    .wr_en_o (wr_en_o),
    .stall_o (stall_o),
    .done_o  (done_o)
);

// File: tb/sprite_copy_dma_test.sv
`timescale 1ns/1ps
module sprite_copy_dma_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [7:0]  page_i = 8'h00;
    logic [7:0]  base_i = 8'h00;
    logic        odd_i = 1'b0;
    logic [7:0]  rd_data_i = 8'h00;
    logic [15:0] rd_addr_o;
    logic        rd_en_o;
    logic [7:0]  wr_addr_o;
    logic [7:0]  wr_data_o;
    logic        wr_en_o;
    logic        stall_o;
    logic        done_o;

    int checks = 0;
    int fails  = 0;
    logic [7:0] oam [256];

    always #2 clk = ~clk;

    sprite_copy_dma uut (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .page_i    (page_i),
        .base_i    (base_i),
        .odd_i     (odd_i),
        .rd_data_i (rd_data_i),
        .rd_addr_o (rd_addr_o),
        .rd_en_o   (rd_en_o),
        .wr_addr_o (wr_addr_o),
        .wr_data_o (wr_data_o),
        .wr_en_o   (wr_en_o),
        .stall_o   (stall_o),
        .done_o    (done_o)
    );

    function automatic logic [7:0] pat(logic [15:0] a);
        logic [7:0] m;
        m = a[7:0] * 8'd7;
        return a[15:8] ^ (m + 8'h3C);
    endfunction

    // Main memory model: data returned the cycle after a request.
    always @(posedge clk) rd_data_i <= rd_en_o ? pat(rd_addr_o) : 8'h00;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(stall_o == 1'b0, "R1", "stall after reset", int'(stall_o), 0);
        chk(done_o  == 1'b0, "R1", "done after reset",  int'(done_o), 0);
        chk(rd_en_o == 1'b0, "R1", "rd_en after reset", int'(rd_en_o), 0);
        chk(wr_en_o == 1'b0, "R1", "wr_en after reset", int'(wr_en_o), 0);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_copy(input logic [7:0] page, input logic [7:0] base,
                          input logic odd, input bit inject, input string tag);
        int n = 0, rdn = 0, wrn = 0, first_rd = -1;
        int rd_bad = 0, wr_bad = 0, data_bad = 0, gap_bad = 0;
        bit prev_rd = 1'b0;
        for (int k = 0; k < 256; k++)
            oam[(base + k) & 8'hFF] = ~pat({page, 8'(k)});
        start_i = 1'b1; page_i = page; base_i = base; odd_i = odd;
        @(negedge clk);
        start_i = 1'b0; page_i = 8'h00; base_i = 8'h00; odd_i = 1'b0;
        while (stall_o && n < 1000) begin
            n++;
            if (prev_rd && !wr_en_o) gap_bad++;
            if (rd_en_o) begin
                if (first_rd < 0) first_rd = n;
                if (rd_addr_o != {page, 8'(rdn)}) rd_bad++;
                rdn++;
            end
            if (wr_en_o) begin
                if (wr_addr_o != 8'(base + wrn)) wr_bad++;
                oam[wr_addr_o] = wr_data_o;
                wrn++;
            end
            prev_rd = rd_en_o;
            // R9: a strobe mid-copy with different settings must be ignored
            if (inject && n == 100) begin
                start_i = 1'b1; page_i = ~page; base_i = base + 8'h11; odd_i = ~odd;
            end else if (inject && n == 101) begin
                start_i = 1'b0; page_i = 8'h00; base_i = 8'h00; odd_i = 1'b0;
            end
            @(negedge clk);
        end
        for (int k = 0; k < 256; k++)
            if (oam[(base + k) & 8'hFF] != pat({page, 8'(k)})) data_bad++;
        if (odd) begin
            chk(n == 514, "R6", {tag, " stall length"}, n, 514);
            chk(first_rd == 3, "R6", {tag, " first read cycle"}, first_rd, 3);
        end else begin
            chk(n == 513, "R5", {tag, " stall length"}, n, 513);
            chk(first_rd == 2, "R5", {tag, " first read cycle"}, first_rd, 2);
        end
        chk(rd_bad == 0 && rdn == 256, "R2", {tag, " read count"}, rdn - rd_bad, 256);
        chk(wr_bad == 0 && wrn == 256, "R3", {tag, " write addresses"}, wrn - wr_bad, 256);
        chk(gap_bad == 0, "R4", {tag, " read-write pairing"}, gap_bad, 0);
        chk(data_bad == 0, inject ? "R9" : "R4", {tag, " bytes mismatched"}, data_bad, 0);
        chk(done_o == 1'b1 && !stall_o, "R8", {tag, " done after last write"}, int'(done_o), 1);
        @(negedge clk);
        chk(done_o == 1'b0, "R8", {tag, " done width"}, int'(done_o), 0);
        chk(!stall_o && !rd_en_o && !wr_en_o, "R7", {tag, " stays free"}, int'(stall_o), 0);
    endtask

    initial begin
        t_reset();
        t_copy(8'h12, 8'h00, 1'b0, 1'b0, "even base0");
        t_copy(8'h80, 8'hC7, 1'b1, 1'b0, "odd wrap");
        t_copy(8'hFF, 8'hFF, 1'b0, 1'b0, "even top");
        t_copy(8'h03, 8'h40, 1'b1, 1'b1, "odd restrike");
        t_copy(8'h5A, 8'h01, 1'b0, 1'b1, "even restrike");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(4 * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule